// File: doc/BRIEF.md
# Programmable-Period GPIO Input Deglitcher

This block cleans up a bank of general-purpose input pins before other logic samples them. Each raw pin is first brought into the clock domain through a two-stage synchronizer. It is then optionally held back by a stability filter. The filtered output only takes a new level once the synchronized input has stayed at that level for a programmed number of clock cycles.

The filter lengths are not stored per pin. Three period registers form a small shared pool. Each pin carries a 2-bit selector that names one of them, or names none, in which case the pin bypasses filtering. Any number of pins may point at the same period. The selector bits are split across two pin-wide select registers: one holds the upper selector bit of every pin and the other holds the lower bit.

Software programs the periods and selectors through a simple single-cycle write port. Each pin runs its own stability counter against whichever period it currently selects.

Top module: `pin_debounce_bank`

## Requirements
- R1: After reset every filtered output is 0, every pin selector is 0 and every period register is 0.
- R2: Each raw input passes through two synchronizing flops. A pin with selector 0 shows a raw change on its filtered output right after the third rising clock edge following the change.
- R3: A filtered output never changes while the synchronized input equals it, and it only ever changes to the synchronized value.
- R4: For a pin with a nonzero selector and period P ≥ 1, a raw change that stays put appears on the filtered output right after the (P+2)-th rising edge following the change. This means the synchronized level was seen on P consecutive edges.
- R5: If the synchronized input returns to the filtered level before P edges have passed, the output does not change and the pin's count is cleared. A later change must again last a full P edges.
- R6: Write address 0 loads the upper selector bit of every pin, with bit n belonging to pin n. Address 1 loads the lower selector bit in the same way. Selector 1, 2 and 3 use the period registers at addresses 2, 3 and 4, taken from the low PERIOD_W data bits.
- R7: Pins holding the same selector are filtered with the same period.
- R8: A select write that changes a pin's selector clears that pin's count. Pins whose selector bits are rewritten unchanged keep counting.
- R9: Any write to a period register clears the count of every pin currently selecting it, even when the written value is unchanged. Pins using other periods keep counting.
- R10: Writes to addresses 5, 6 and 7 change no selector, no period and no filtered output.
- R11: A period register holding 0 filters exactly like a period of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 3 | Register address of the write |
| wr_data_i | input | DATA_W | Write data |
| pin_raw_i | input | NUM_PINS | Asynchronous raw pin levels |
| pin_filt_o | output | NUM_PINS | Synchronized and filtered pin levels |

## Verification
The bench builds the block with 8 pins and 8-bit period registers, keeping the data path at 32 bits. With these settings, several pins can share or differ in selector within one register write. Periods of 3 to 10 cycles make every count boundary, glitch and mid-count reconfiguration visible in a few dozen cycles. The tests check, one edge at a time, the cycle just before and the cycle of each output change. They also place select and period writes in the middle of a count, so that a missing count clear moves an edge early.

// File: rtl/dbn_pkg.sv
`timescale 1ns/1ps
package dbn_pkg;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned IDX_W   = 2;
    localparam int unsigned NUM_TMR = 3;

    localparam logic [ADDR_W-1:0] SEL_HI_ADDR   = 3'd0;
    localparam logic [ADDR_W-1:0] SEL_LO_ADDR   = 3'd1;
    localparam logic [ADDR_W-1:0] TMR_BASE_ADDR = 3'd2;
    localparam logic [ADDR_W-1:0] TMR_LAST_ADDR = TMR_BASE_ADDR + ADDR_W'(NUM_TMR - 1);
endpackage

// File: rtl/dbn_sync.sv
`timescale 1ns/1ps
module dbn_sync #(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] raw_i,
    output logic [NUM_PINS-1:0] sync_o
);
    typedef logic [STAGES-1:0][NUM_PINS-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbn_cfg_regs.sv
`timescale 1ns/1ps
module dbn_cfg_regs
    import dbn_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned PERIOD_W = 32,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en_i,
    input  logic [ADDR_W-1:0]                   wr_addr_i,
    input  logic [DATA_W-1:0]                   wr_data_i,
    output logic [NUM_PINS-1:0][IDX_W-1:0]      sel_idx_o,
    output logic [NUM_TMR-1:0][PERIOD_W-1:0]    period_o,
    output logic [NUM_PINS-1:0]                 restart_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0]              hi;
        logic [NUM_PINS-1:0]              lo;
        logic [NUM_TMR-1:0][PERIOD_W-1:0] per;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [NUM_TMR:0] tmr_wr;

    always_comb begin
        cfg_d     = cfg_q;
        tmr_wr    = '0;
        restart_o = '0;

        if (wr_en_i && (wr_addr_i == SEL_HI_ADDR)) cfg_d.hi = wr_data_i[NUM_PINS-1:0];
        if (wr_en_i && (wr_addr_i == SEL_LO_ADDR)) cfg_d.lo = wr_data_i[NUM_PINS-1:0];

        // slot 0 of tmr_wr stands for "no timer" and is never written
        for (int t = 0; t < NUM_TMR; t++) begin
            if (wr_en_i && (wr_addr_i == TMR_BASE_ADDR + ADDR_W'(t))) begin
                cfg_d.per[t] = wr_data_i[PERIOD_W-1:0];
                tmr_wr[t+1]  = 1'b1;
            end
        end

        for (int p = 0; p < NUM_PINS; p++) begin
            restart_o[p] = (cfg_d.hi[p] != cfg_q.hi[p])
                        || (cfg_d.lo[p] != cfg_q.lo[p])
                        || tmr_wr[{cfg_q.hi[p], cfg_q.lo[p]}];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            sel_idx_o[p] = {cfg_q.hi[p], cfg_q.lo[p]};
        end
        period_o = cfg_q.per;
    end
endmodule

// File: rtl/dbn_pin_filter.sv
`timescale 1ns/1ps
module dbn_pin_filter
    import dbn_pkg::*;
#(
    parameter int unsigned PERIOD_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sync_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [NUM_TMR-1:0][PERIOD_W-1:0] period_i,
    input  logic                             restart_i,
    output logic                             filt_o
);
    typedef struct packed {
        logic                filt;
        logic [PERIOD_W-1:0] cnt;
    } pin_st_t;

    pin_st_t           st_d, st_q;
    logic [PERIOD_W-1:0] limit;
    logic [PERIOD_W:0]   cnt_inc;

    always_comb begin
        st_d    = st_q;
        limit   = '0;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;

        case (idx_i)
            2'd1:    limit = period_i[0];
            2'd2:    limit = period_i[1];
            2'd3:    limit = period_i[2];
            default: limit = '0;
        endcase

        if (idx_i == '0) begin
            st_d.filt = sync_i;
            st_d.cnt  = '0;
        end else if (restart_i || (sync_i == st_q.filt)) begin
            st_d.cnt = '0;
        end else if (cnt_inc >= {1'b0, limit}) begin
            st_d.filt = sync_i;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = cnt_inc[PERIOD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = st_q.filt;
endmodule

// File: rtl/pin_debounce_bank.sv
`timescale 1ns/1ps
module pin_debounce_bank
    import dbn_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned PERIOD_W = 32,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [NUM_PINS-1:0] pin_raw_i,
    output logic [NUM_PINS-1:0] pin_filt_o
);
    logic [NUM_PINS-1:0]              sync_w;
    logic [NUM_PINS-1:0][IDX_W-1:0]   sel_idx_w;
    logic [NUM_TMR-1:0][PERIOD_W-1:0] period_w;
    logic [NUM_PINS-1:0]              restart_w;

    dbn_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (2)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_raw_i),
        .sync_o (sync_w)
    );

    dbn_cfg_regs #(
        .NUM_PINS (NUM_PINS),
        .PERIOD_W (PERIOD_W),
        .DATA_W   (DATA_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .sel_idx_o (sel_idx_w),
        .period_o  (period_w),
        .restart_o (restart_w)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        dbn_pin_filter #(
            .PERIOD_W (PERIOD_W)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_i    (sync_w[p]),
            .idx_i     (sel_idx_w[p]),
            .period_i  (period_w),
            .restart_i (restart_w[p]),
            .filt_o    (pin_filt_o[p])
        );
    end
endmodule

// File: rtl/dbn_checker.sv
`timescale 1ns/1ps
module dbn_checker
    import dbn_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned DATA_W   = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic [ADDR_W-1:0]              wr_addr,
    input logic [DATA_W-1:0]              wr_data,
    input logic [NUM_PINS-1:0]            pin_raw,
    input logic [NUM_PINS-1:0]            sync,
    input logic [NUM_PINS-1:0][IDX_W-1:0] idx,
    input logic [NUM_PINS-1:0]            filt
);
    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    assert_sync_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (sync == $past(pin_raw, 2)));

    assert_unused_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > TMR_LAST_ADDR)) |=> $stable(idx));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (idx[p] == 2'd0) |=> (filt[p] == $past(sync[p])));

        assert_hold_when_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sync[p] == filt[p]) |=> $stable(filt[p]));

        assert_move_to_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ((warm_q != 2'd0) && (filt[p] != $past(filt[p]))) |-> (filt[p] == $past(sync[p])));

        assert_sel_hi_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == SEL_HI_ADDR)) |=> (idx[p][1] == $past(wr_data[p])));

        assert_sel_lo_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == SEL_LO_ADDR)) |=> (idx[p][0] == $past(wr_data[p])));
    end
endmodule

bind pin_debounce_bank dbn_checker #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .pin_raw (pin_raw_i),
    .sync    (sync_w),
    .idx     (sel_idx_w),
    .filt    (pin_filt_o)
);

// File: tb/pin_debounce_bank_tb.sv
`timescale 1ns/1ps
module pin_debounce_bank_tb;
    localparam int NP = 8;
    localparam int PW = 8;
    localparam int DW = 32;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NP-1:0] raw = '0;
    logic [NP-1:0] filt;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pin_debounce_bank #(.NUM_PINS(NP), .PERIOD_W(PW), .DATA_W(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .pin_raw_i  (raw),
        .pin_filt_o (filt)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [NP-1:0] exp);
        n_checks++;
        if (filt !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, filt, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; raw = '0; wr_en = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    // R1 and R2: reset state, bypass latency, zero periods after reset
    task automatic t_reset();
        do_reset();
        check("R1 reset output", 8'h00);
        raw = 8'hA5;
        step(2); check("R2 bypass before third edge", 8'h00);
        step(1); check("R2 bypass after third edge", 8'hA5);
        wr(3'd1, 32'h01);
        raw = 8'hA4;
        step(2); check("R1 zero period before edge", 8'hA5);
        step(1); check("R1 zero period after edge", 8'hA4);
    endtask

    // R4 and R6: per-pin periods through the split selector bits
    task automatic t_debounce();
        do_reset();
        wr(3'd2, 32'd10);
        wr(3'd4, 32'd6);
        wr(3'd0, 32'h02);
        wr(3'd1, 32'h03);
        raw = 8'h03;
        step(7); check("R4 rise held", 8'h00);
        step(1); check("R6 selector 3 period 6", 8'h02);
        step(3); check("R4 period 10 held", 8'h02);
        step(1); check("R4 period 10 taken", 8'h03);
        raw = 8'h00;
        step(8); check("R4 fall period 6", 8'h01);
        step(4); check("R4 fall period 10", 8'h00);
    endtask

    // R5 and R3: short pulses ignored, count cleared
    task automatic t_glitch();
        do_reset();
        wr(3'd2, 32'd5);
        wr(3'd1, 32'hFF);
        raw = 8'hFF;
        step(4);
        raw = 8'h00;
        step(2);
        raw = 8'hFF;
        step(6); check("R5 count cleared by return", 8'h00);
        step(1); check("R5 full period after glitch", 8'hFF);
        raw = 8'h00;
        step(3);
        raw = 8'hFF;
        step(12); check("R3 R5 short low pulse ignored", 8'hFF);
    endtask

    // R7: shared selectors share a period
    task automatic t_shared();
        do_reset();
        wr(3'd2, 32'd10);
        wr(3'd3, 32'd4);
        wr(3'd0, 32'h03);
        wr(3'd1, 32'h04);
        raw = 8'h07;
        step(5); check("R7 shared before", 8'h00);
        step(1); check("R7 shared pair", 8'h03);
        step(5); check("R7 other timer held", 8'h03);
        step(1); check("R7 other timer taken", 8'h07);
    endtask

    // R8: select change restarts only the changed pin
    task automatic t_sel_restart();
        do_reset();
        wr(3'd2, 32'd10);
        wr(3'd4, 32'd4);
        wr(3'd1, 32'h03);
        raw = 8'h03;
        step(4);
        wr(3'd0, 32'h01);
        step(3); check("R8 changed pin restarted", 8'h00);
        step(1); check("R8 changed pin new period", 8'h01);
        step(2); check("R8 unchanged pin still counting", 8'h01);
        step(1); check("R8 unchanged pin on time", 8'h03);
    endtask

    // R9: period write restarts its users only
    task automatic t_period_restart();
        do_reset();
        wr(3'd2, 32'd10);
        wr(3'd3, 32'd3);
        wr(3'd1, 32'h03);
        wr(3'd0, 32'h04);
        raw = 8'h07;
        step(4);
        wr(3'd2, 32'd10);
        check("R9 other timer unaffected", 8'h04);
        step(6); check("R9 no early update", 8'h04);
        step(3); check("R9 restarted held", 8'h04);
        step(1); check("R9 restarted taken", 8'h07);
    endtask

    // R10: unused addresses ignored
    task automatic t_unused();
        do_reset();
        wr(3'd2, 32'd10);
        wr(3'd1, 32'h01);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        raw = 8'h03;
        step(3); check("R10 bypass pin kept", 8'h02);
        step(8); check("R10 period kept", 8'h02);
        step(1); check("R10 period kept taken", 8'h03);
    endtask

    // R11: zero period behaves as one
    task automatic t_zero_period();
        do_reset();
        wr(3'd4, 32'd7);
        wr(3'd0, 32'h01);
        wr(3'd1, 32'h01);
        wr(3'd4, 32'd0);
        raw = 8'h01;
        step(2); check("R11 zero period before", 8'h00);
        step(1); check("R11 zero period taken", 8'h01);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_debounce();
        t_glitch();
        t_shared();
        t_sel_restart();
        t_period_restart();
        t_unused();
        t_zero_period();
        summary();
        $finish;
    end
endmodule